// File: doc/BRIEF.md
# Inversion-Reseeded LFSR Pattern Generator

This block produces one test pattern per clock from a shift register with external XOR feedback. It does not read new seeds from a stored table. Instead, on chosen cycles it flips selected bits of the next state, so the register lands directly on the state that a hard-to-detect fault needs. A free-running vector counter drives a small decoder. For each scheduled vector index, the decoder raises one control line for each stage that must be inverted. Only the stages named in a parameter get an inversion XOR.

In normal mode the register acts as an ordinary parallel register fed from the functional path. In test mode a one-cycle start pulse loads the initial seed and clears the counter. The register then steps once per clock until the final vector index is reached. At that point the end flag rises and the register holds its value.

Bit order: `pattern[WIDTH-1]` is the first stage and `pattern[0]` is the last stage. All masks and seeds use this same order.

Top module: `lfsr_reseed_gen`

## Requirements
- R1: While reset is active, and after it is released with test mode high and no start pulse, `pattern` is all zeros and `test_end` is 0.
- R2: With `test_mode` low, the state after each clock equals `func_d` sampled at that clock. This holds even when the decoded inversion lines are active.
- R3: A clock with `test_mode` high and `start` high loads `SEED` as vector 0 and clears the vector counter. This also applies when a run is already in progress.
- R4: In a step, the new first stage is the XOR of the stages selected by `TAPS`, and every other stage takes the value of the stage before it. For the 4-stage case with `TAPS`=4'b1001 and seed 1010, the first vectors are 1010, 1101, 0110, 0011.
- R5: A schedule entry (v, mask) makes vector v equal to the plain step from vector v-1, XOR `mask`. The inversion lines are decoded while the counter shows v-1. In the default case, entries (3, 0010) and (5, 0011) give the sequence 1010, 1101, 0110, 0001, 1000, 1111, 0111, 1011.
- R6: A mask bit on a stage whose `INV_STAGES` bit is 0 has no effect. In the default case, the entry (2, 1000) leaves vector 2 at 0110.
- R7: `test_end` is 1 exactly while vector `TOTAL_VEC`-1 is on `pattern` in a run. After that the pattern holds for as long as test mode stays high without a start pulse.
- R8: In test mode with no run active, `pattern` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| test_mode | input | 1 | 1 = pattern generation, 0 = functional parallel load |
| start | input | 1 | One-cycle pulse that seeds the register and starts a run |
| func_d | input | WIDTH | Functional parallel data |
| pattern | output | WIDTH | Current register state, applied to the circuit under test |
| test_end | output | 1 | Final vector of the run reached |

## Verification
Every cycle, the assertions check the following: a functional load captures `func_d` exactly, a start pulse lands on the seed, an idle or finished register does not move, and the counter never passes the final index. Only the bench's scenarios can show whole sequences. These are the plain polynomial run and the run with inversions, which are compared vector by vector against the expected sequences. The bench also shows that a mask bit on a stage without an XOR is dropped, and that a functional load taken while an inversion line is active stays clean.

// File: rtl/lfsr_rsd_pkg.sv
package lfsr_rsd_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_LOAD = 2'd1,
    OP_SEED = 2'd2,
    OP_STEP = 2'd3
  } rsd_op_e;
endpackage

// File: rtl/lfsr_rsd_counter.sv
module lfsr_rsd_counter #(
  parameter int CNT_W     = 16,
  parameter int TOTAL_VEC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  output logic [CNT_W-1:0] cnt,
  output logic             last
);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(TOTAL_VEC - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (adv) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (clr || adv) cnt_q <= cnt_d;
  end

  assign cnt  = cnt_q;
  assign last = (cnt_q == LAST_CNT);

  // R7: advance is by one, and the index never runs past the final vector
  p_cnt_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr) |=> cnt_q == $past(cnt_q) + 1'b1);
  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST_CNT);
endmodule

// File: rtl/lfsr_rsd_inv_ctrl.sv
module lfsr_rsd_inv_ctrl #(
  parameter int                          WIDTH    = 4,
  parameter int                          CNT_W    = 16,
  parameter int                          NUM_RSD  = 3,
  parameter logic [NUM_RSD*CNT_W-1:0]    RSD_AT   = '0,
  parameter logic [NUM_RSD*WIDTH-1:0]    RSD_MASK = '0
) (
  input  logic [CNT_W-1:0] cnt,
  output logic [WIDTH-1:0] ctrl
);
  logic [CNT_W-1:0] next_idx;
  logic [WIDTH-1:0] hit_mask [NUM_RSD];

  assign next_idx = cnt + 1'b1;

  // one comparator per schedule entry: raise that entry's mask one cycle early
  for (genvar e = 0; e < NUM_RSD; e++) begin : g_entry
    localparam logic [CNT_W-1:0] AT_V   = RSD_AT[e*CNT_W +: CNT_W];
    localparam logic [WIDTH-1:0] MASK_V = RSD_MASK[e*WIDTH +: WIDTH];
    assign hit_mask[e] = (next_idx == AT_V) ? MASK_V : '0;
  end

  always_comb begin
    ctrl = '0;
    for (int e = 0; e < NUM_RSD; e++) ctrl = ctrl | hit_mask[e];
  end
endmodule

// File: rtl/lfsr_rsd_shreg.sv
module lfsr_rsd_shreg
  import lfsr_rsd_pkg::*;
#(
  parameter int               WIDTH      = 4,
  parameter logic [WIDTH-1:0] TAPS       = 4'b1001,
  parameter logic [WIDTH-1:0] SEED       = 4'b1010,
  parameter logic [WIDTH-1:0] INV_STAGES = 4'b0011
) (
  input  logic             clk,
  input  logic             rst_n,
  input  rsd_op_e          op,
  input  logic [WIDTH-1:0] func_d,
  input  logic [WIDTH-1:0] ctrl,
  output logic [WIDTH-1:0] state
);
  logic [WIDTH-1:0] state_q, state_d;
  logic [WIDTH-1:0] shifted, stepped;
  logic             fb;
  logic             en;

  assign fb      = ^(state_q & TAPS);
  assign shifted = {fb, state_q[WIDTH-1:1]};
  // inversion gates exist only on stages listed in INV_STAGES
  assign stepped = shifted ^ (ctrl & INV_STAGES);

  always_comb begin
    state_d = state_q;
    unique case (op)
      OP_LOAD: state_d = func_d;
      OP_SEED: state_d = SEED;
      OP_STEP: state_d = stepped;
      default: state_d = state_q;
    endcase
  end

  assign en = (op != OP_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  state_q <= '0;
    else if (en) state_q <= state_d;
  end

  assign state = state_q;

  p_func_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_LOAD) |=> state_q == $past(func_d));
  p_seed_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SEED) |=> state_q == SEED);
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_IDLE) |=> $stable(state_q));
  p_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_STEP && ctrl == '0) |=> state_q[WIDTH-2:0] == $past(state_q[WIDTH-1:1]));
endmodule

// File: rtl/lfsr_reseed_gen.sv
module lfsr_reseed_gen
  import lfsr_rsd_pkg::*;
#(
  parameter int                       WIDTH      = 4,
  parameter int                       CNT_W      = 16,
  parameter int                       TOTAL_VEC  = 8,
  parameter logic [WIDTH-1:0]         TAPS       = 4'b1001,
  parameter logic [WIDTH-1:0]         SEED       = 4'b1010,
  parameter logic [WIDTH-1:0]         INV_STAGES = 4'b0011,
  parameter int                       NUM_RSD    = 3,
  parameter logic [NUM_RSD*CNT_W-1:0] RSD_AT     = {16'd2, 16'd5, 16'd3},
  parameter logic [NUM_RSD*WIDTH-1:0] RSD_MASK   = {4'b1000, 4'b0011, 4'b0010}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             test_mode,
  input  logic             start,
  input  logic [WIDTH-1:0] func_d,
  output logic [WIDTH-1:0] pattern,
  output logic             test_end
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             run_q, run_d;
  logic [CNT_W-1:0] cnt;
  logic             last;
  logic [WIDTH-1:0] ctrl;
  rsd_op_e          op;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  always_comb begin
    if (!test_mode)           op = OP_LOAD;
    else if (start)           op = OP_SEED;
    else if (run_q && !last)  op = OP_STEP;
    else                      op = OP_IDLE;
  end

  always_comb begin
    run_d = run_q;
    if (!test_mode) run_d = 1'b0;
    else if (start) run_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) run_q <= 1'b0;
    else            run_q <= run_d;
  end

  lfsr_rsd_counter #(
    .CNT_W     (CNT_W),
    .TOTAL_VEC (TOTAL_VEC)
  ) u_counter (
    .clk   (clk),
    .rst_n (rst_int_n),
    .clr   (op == OP_SEED),
    .adv   (op == OP_STEP),
    .cnt   (cnt),
    .last  (last)
  );

  lfsr_rsd_inv_ctrl #(
    .WIDTH    (WIDTH),
    .CNT_W    (CNT_W),
    .NUM_RSD  (NUM_RSD),
    .RSD_AT   (RSD_AT),
    .RSD_MASK (RSD_MASK)
  ) u_inv_ctrl (
    .cnt  (cnt),
    .ctrl (ctrl)
  );

  lfsr_rsd_shreg #(
    .WIDTH      (WIDTH),
    .TAPS       (TAPS),
    .SEED       (SEED),
    .INV_STAGES (INV_STAGES)
  ) u_shreg (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .op     (op),
    .func_d (func_d),
    .ctrl   (ctrl),
    .state  (pattern)
  );

  assign test_end = run_q && last;

  p_end_hold_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (test_mode && test_end && !start) |=> (test_end && $stable(pattern)));
  p_end_needs_run_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    test_end |-> test_mode);
endmodule

// File: tb/lfsr_reseed_gen_bench.sv
module lfsr_reseed_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       test_mode;
  logic       start;
  logic [3:0] func_d;
  logic [3:0] pat_rsd, pat_plain;
  logic       end_rsd, end_plain;
  int         checks = 0;
  int         fails  = 0;

  always #10 clk = ~clk;

  localparam logic [3:0] EXP_RSD [8] = '{
    4'b1010, 4'b1101, 4'b0110, 4'b0001, 4'b1000, 4'b1111, 4'b0111, 4'b1011};
  localparam logic [3:0] EXP_PLAIN [15] = '{
    4'b1010, 4'b1101, 4'b0110, 4'b0011, 4'b1001, 4'b0100, 4'b0010, 4'b0001,
    4'b1000, 4'b1100, 4'b1110, 4'b1111, 4'b0111, 4'b1011, 4'b0101};

  lfsr_reseed_gen #(.TOTAL_VEC(8)) u_lfsr_reseed_gen (
    .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .start(start),
    .func_d(func_d), .pattern(pat_rsd), .test_end(end_rsd));

  // same schedule, but no stage carries an inversion gate
  lfsr_reseed_gen #(.TOTAL_VEC(15), .INV_STAGES(4'b0000)) u_plain (
    .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .start(start),
    .func_d(func_d), .pattern(pat_plain), .test_end(end_plain));

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_start();
    start = 1'b1;
    tick();
    start = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; test_mode = 1'b1; start = 1'b0; func_d = 4'b0000;
    repeat (3) @(negedge clk);
    chk("R1 reset pattern", pat_rsd, 4'b0000);
    chk("R1 reset end", {3'b0, end_rsd}, 4'b0000);
    rst_n = 1'b1;
    repeat (4) tick();
    chk("R1/R8 idle after release", pat_rsd, 4'b0000);
    chk("R8 idle end flag", {3'b0, end_plain}, 4'b0000);

    // main run: table walk of both instances
    pulse_start();
    for (int i = 0; i < 15; i++) begin
      chk($sformatf("R5/R6 reseeded vector %0d", i), pat_rsd, EXP_RSD[(i < 8) ? i : 7]);
      chk($sformatf("R7 reseeded end %0d", i), {3'b0, end_rsd}, {3'b0, (i >= 7)});
      chk($sformatf("R4 plain vector %0d", i), pat_plain, EXP_PLAIN[i]);
      chk($sformatf("R7 plain end %0d", i), {3'b0, end_plain}, {3'b0, (i == 14)});
      tick();
    end
    repeat (3) tick();
    chk("R7 reseeded hold", pat_rsd, 4'b1011);
    chk("R7 plain hold", pat_plain, 4'b0101);
    chk("R7 end stays", {3'b0, end_plain}, 4'b0001);

    // functional load while an inversion line is decoded (counter at 2)
    pulse_start();
    chk("R3 reseed vector 0", pat_rsd, 4'b1010);
    tick(); tick();
    chk("R5 pre-load vector 2", pat_rsd, 4'b0110);
    test_mode = 1'b0; func_d = 4'b0101;
    tick();
    chk("R2 load with inversion active", pat_rsd, 4'b0101);
    chk("R2 end low in normal mode", {3'b0, end_rsd}, 4'b0000);
    func_d = 4'b1100;
    tick();
    chk("R2 second load", pat_rsd, 4'b1100);
    chk("R2 plain load", pat_plain, 4'b1100);

    // back to test mode without a start pulse: idle
    test_mode = 1'b1; func_d = 4'b0011;
    tick(); tick();
    chk("R8 idle hold", pat_rsd, 4'b1100);

    // restart in the middle of a run
    pulse_start();
    tick(); tick(); tick();
    chk("R5 mid run vector 3", pat_rsd, 4'b0001);
    pulse_start();
    chk("R3 restart mid run", pat_rsd, 4'b1010);
    tick();
    chk("R3 counter cleared", pat_rsd, 4'b1101);

    // reset during a run
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 async reset", pat_rsd, 4'b0000);
    rst_n = 1'b1;

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule